// File: doc/BRIEF.md
# Converter Serial Port Model (Chip-Select Mode with Busy Indicator)

This block is a synthesizable, device-side model of the digital serial port of a successive-approximation converter. It runs in 3-wire chip-select mode with a busy indicator. It exists to exercise host controllers: the host drives the convert strobe, a configuration level and the serial clock. The model answers on a tristate data line. The line's enable and its data value are separate outputs, so a bench can place its own pull-up on the line.

A rising convert strobe, seen while the configuration input is high, latches a 16-bit sample word from an input port and starts a conversion. The conversion lasts a set number of system clock cycles. During that time the data line is released. When the conversion ends, the model pulls the line low as an end-of-conversion marker, but only if the strobe is low at that moment. The host then clocks the word out, most significant bit first, one bit per falling serial clock edge. The line is released after the seventeenth falling edge, or earlier when a new rising strobe arrives. A host that still holds the strobe high when the shortest legal conversion time has passed is flagged on a violation output.

All inputs are taken to be synchronous to the system clock. Each edge of the strobe or the serial clock is recognised one register stage after it is sampled.

Top module: `sar_port_model`

## Requirements
- R1: A rising convert strobe with the configuration input high starts a conversion, latches `sample_i` at that edge and leaves `sdo_oe_o` low one clock later. A rising strobe with the configuration input low starts nothing.
- R2: While a conversion runs (`CONV_MAX` clocks), `sdo_oe_o` stays low. Further strobe edges and serial clock edges have no effect, and the data read later is the word latched at the start.
- R3: `CONV_MAX` clocks after the starting edge, if the strobe is low, `sdo_oe_o` goes to 1 with `sdo_o` at 0. If the strobe is high at that moment, the line stays released and the port goes idle.
- R4: The first falling serial clock edge after completion puts bit 15 on `sdo_o`. Each later falling edge puts the next lower bit. While the line is enabled, `sdo_o` changes only after a falling edge. A rising serial clock edge leaves `sdo_o` unchanged.
- R5: The 17th falling serial clock edge after completion sets `sdo_oe_o` to 0.
- R6: A rising strobe while the line is enabled (at the low marker or during readout) sets `sdo_oe_o` to 0 one clock later. If the configuration input is high, that edge also starts a fresh conversion with a new sample. If it is low, no conversion follows.
- R7: `violation_o` is set when the strobe is high `CONV_MIN` clocks after the starting edge. It stays set until the next conversion start, which clears it.
- R8: After reset, `sdo_oe_o`, `sdo_o` and `violation_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Convert strobe / chip select from the host |
| cfg_i | input | 1 | Configuration level; high selects chip-select mode |
| sck_i | input | 1 | Serial clock from the host |
| sample_i | input | WORD_W | Sample word to be reported by the next conversion |
| sdo_o | output | 1 | Data line value when enabled |
| sdo_oe_o | output | 1 | Data line enable; 0 means high impedance |
| violation_o | output | 1 | Sticky flag: strobe high at the minimum conversion time |

## Verification
Every strobe or serial clock change made after a falling system clock edge shows on the outputs one clock later. The bench drives after a falling edge and samples after the next falling edge. The completion marker is due exactly `CONV_MAX` clocks after the clock that registered the starting edge, and the violation flag exactly `CONV_MIN` clocks after it. The bench counts those clocks out and checks one clock before each deadline, where the old value must still hold, and again at the deadline. During readout, every serial clock half-period is one system clock, and each bit is checked in the clock after its falling edge.

// File: rtl/sarp_pkg.sv
package sarp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2,
    ST_SHIFT = 2'd3
  } port_state_e;

  // True in the last cycle of a window of lim cycles counted from zero.
  function automatic logic window_end(input int unsigned cnt, input int unsigned lim);
    return cnt == lim - 1;
  endfunction

  // Bit of a word at a given position, counting from the LSB.
  function automatic logic word_bit(input logic [31:0] word, input int unsigned pos);
    return word[pos[4:0]];
  endfunction

endpackage

// File: rtl/sarp_edge.sv
module sarp_edge #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] sig_i,
  output logic [LANES-1:0] rise_o,
  output logic [LANES-1:0] fall_o
);
  logic [LANES-1:0] prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end
endmodule

// File: rtl/sarp_timer.sv
module sarp_timer
  import sarp_pkg::*;
#(
  parameter int CONV_MIN = 12,
  parameter int CONV_MAX = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic min_hit_o,
  output logic max_hit_o
);
  localparam int CW = $clog2(CONV_MAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) cnt_q <= '0;
    else if (run_i)        cnt_q <= cnt_q + 1'b1;
  end

  assign min_hit_o = run_i && window_end(int'(cnt_q), CONV_MIN);
  assign max_hit_o = run_i && window_end(int'(cnt_q), CONV_MAX);
endmodule

// File: rtl/sarp_shift.sv
module sarp_shift
  import sarp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              first_i,
  input  logic              step_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  logic [WORD_W-1:0] word_q;
  logic [IW-1:0]     idx_q;
  logic [31:0]       word_ext;

  always_ff @(posedge clk) begin
    if (!rst_n)      word_q <= '0;
    else if (load_i) word_q <= sample_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (first_i) idx_q <= IW'(WORD_W - 1);
    else if (step_i)  idx_q <= idx_q - 1'b1;
  end

  assign word_ext = 32'(word_q);
  assign bit_o    = word_bit(word_ext, int'(idx_q));
  assign last_o   = (idx_q == '0);
endmodule

// File: rtl/sar_port_model.sv
module sar_port_model
  import sarp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CONV_MIN = 12,
  parameter int CONV_MAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              cfg_i,
  input  logic              sck_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              violation_o
);
  port_state_e state_q, state_d;
  logic [1:0]  rise, fall;
  logic        ev_cnv_rise, ev_sck_fall;
  logic        ev_start, ev_done, ev_min, ev_max;
  logic        in_conv, ev_first, ev_step, shift_bit, shift_last;
  logic        viol_q;

  sarp_edge #(.LANES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_i({sck_i, cnv_i}),
    .rise_o(rise), .fall_o(fall)
  );
  assign ev_cnv_rise = rise[0];
  assign ev_sck_fall = fall[1];

  assign in_conv  = (state_q == ST_CONV);
  assign ev_start = ev_cnv_rise && cfg_i && !in_conv;
  assign ev_done  = ev_max && !cnv_i;
  assign ev_first = (state_q == ST_READY) && ev_sck_fall && !ev_cnv_rise;
  assign ev_step  = (state_q == ST_SHIFT) && ev_sck_fall && !ev_cnv_rise;

  sarp_timer #(.CONV_MIN(CONV_MIN), .CONV_MAX(CONV_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(ev_start), .run_i(in_conv),
    .min_hit_o(ev_min), .max_hit_o(ev_max)
  );

  sarp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(ev_start), .sample_i(sample_i),
    .first_i(ev_first), .step_i(ev_step),
    .bit_o(shift_bit), .last_o(shift_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ev_start) state_d = ST_CONV;
      ST_CONV:  if (ev_max) state_d = cnv_i ? ST_IDLE : ST_READY;
      ST_READY: begin
        if (ev_cnv_rise)      state_d = cfg_i ? ST_CONV : ST_IDLE;
        else if (ev_sck_fall) state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (ev_cnv_rise)               state_d = cfg_i ? ST_CONV : ST_IDLE;
        else if (ev_step && shift_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               viol_q <= 1'b0;
    else if (ev_start)        viol_q <= 1'b0;
    else if (ev_min && cnv_i) viol_q <= 1'b1;
  end

  assign sdo_oe_o    = (state_q == ST_READY) || (state_q == ST_SHIFT);
  assign sdo_o       = (state_q == ST_SHIFT) ? shift_bit : 1'b0;
  assign violation_o = viol_q;
endmodule

// File: rtl/sarp_chk.sv
module sarp_chk (
  input logic clk,
  input logic rst_n,
  input logic cnv_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic violation_o,
  input logic ev_start,
  input logic ev_done,
  input logic ev_sck_fall,
  input logic ev_cnv_rise
);
  // R1
  start_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sdo_oe_o);

  // R3
  marker_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> ($past(ev_done) && !sdo_o));

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(ev_sck_fall)) |-> $stable(sdo_o));

  // R6
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnv_rise && sdo_oe_o) |=> !sdo_oe_o);

  // R7
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(violation_o) |-> $past(cnv_i));

  // R7
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !violation_o);
endmodule

bind sar_port_model sarp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_i(cnv_i), .sdo_o(sdo_o),
  .sdo_oe_o(sdo_oe_o), .violation_o(violation_o),
  .ev_start(ev_start), .ev_done(ev_done),
  .ev_sck_fall(ev_sck_fall), .ev_cnv_rise(ev_cnv_rise)
);

// File: tb/sim_sar_port_model.sv
module sim_sar_port_model;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int CMIN = 5;
  localparam int CMAX = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, cfg = 1'b1, sck = 1'b0;
  logic [W-1:0] sample = '0;
  logic sdo, oe, viol;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_port_model #(.WORD_W(W), .CONV_MIN(CMIN), .CONV_MAX(CMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .cfg_i(cfg), .sck_i(sck),
    .sample_i(sample), .sdo_o(sdo), .sdo_oe_o(oe), .violation_o(viol)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Start a conversion of w and run it to the completion marker.
  task automatic convert(input logic [W-1:0] w);
    sample = w; cfg = 1'b1; cnv = 1'b1;
    tick(1);
    check("R1 released after start", 32'(oe), 0);
    cnv = 1'b0; sample = ~w;          // R1: later sample changes are not taken
    tick(CMAX - 1);
    check("R2 still released before deadline", 32'(oe), 0);
    tick(1);
    check("R3 marker enable", 32'(oe), 1);
    check("R3 marker low", 32'(sdo), 0);
    check("R7 no violation", 32'(viol), 0);
  endtask

  // Shift out n bits of w starting at the MSB.
  task automatic read_bits(input logic [W-1:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; tick(1);
      if (i == 0) check("R4 rising edge keeps marker", 32'(sdo), 0);
      sck = 1'b0; tick(1);
      check("R4 bit value", 32'(sdo), 32'(w[W-1-i]));
      check("R4 line enabled", 32'(oe), 1);
    end
  endtask

  task automatic read_word(input logic [W-1:0] w);
    read_bits(w, W);
    sck = 1'b1; tick(1);
    check("R5 enabled before 17th fall", 32'(oe), 1);
    sck = 1'b0; tick(1);
    check("R5 released after 17th fall", 32'(oe), 0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] pats [4];
    pats[0] = '0; pats[1] = '1; pats[2] = 16'hA5C3; pats[3] = 16'h5A3C;
    tick(3);
    // R8
    check("R8 oe after reset", 32'(oe), 0);
    check("R8 sdo after reset", 32'(sdo), 0);
    check("R8 viol after reset", 32'(viol), 0);
    rst_n = 1'b1;
    tick(2);

    // R4 walking-one and fixed patterns
    for (int b = 0; b < W; b++) begin
      convert(W'(1) << b);
      read_word(W'(1) << b);
    end
    for (int p = 0; p < 4; p++) begin
      convert(pats[p]);
      read_word(pats[p]);
    end

    // R1: strobe with configuration low starts nothing
    cfg = 1'b0; cnv = 1'b1; tick(1);
    cnv = 1'b0; tick(CMAX + 2);
    check("R1 cfg low no conversion", 32'(oe), 0);

    // R2: strobe and clock activity during conversion ignored
    sample = 16'h3C96; cfg = 1'b1; cnv = 1'b1; tick(1);
    cnv = 1'b0; sample = 16'h0F0F;
    sck = 1'b1; tick(1);
    sck = 1'b0; cnv = 1'b1; tick(1);
    cnv = 1'b0; tick(1);
    check("R2 released during conversion", 32'(oe), 0);
    tick(CMAX - 4);
    check("R2 not finished early", 32'(oe), 0);
    tick(1);
    check("R2 completes on schedule", 32'(oe), 1);
    read_word(16'h3C96);

    // R6: abort during readout and restart
    convert(16'hBEEF);
    read_bits(16'hBEEF, 5);
    convert(16'h1234);
    read_word(16'h1234);

    // R6: strobe at marker with configuration low releases only
    convert(16'h7777);
    cfg = 1'b0; cnv = 1'b1; tick(1);
    check("R6 released at marker", 32'(oe), 0);
    cnv = 1'b0; tick(CMAX + 2);
    check("R6 no new conversion", 32'(oe), 0);
    cfg = 1'b1;

    // R7 and R3: strobe held high through the conversion
    sample = 16'h4242; cnv = 1'b1; tick(1);
    tick(CMIN - 1);
    check("R7 flag clear before minimum", 32'(viol), 0);
    tick(1);
    check("R7 flag set at minimum", 32'(viol), 1);
    tick(CMAX - CMIN);
    check("R3 no marker while strobe high", 32'(oe), 0);
    cnv = 1'b0; tick(3);
    check("R7 flag sticky", 32'(viol), 1);
    check("R3 port idle", 32'(oe), 0);
    convert(16'h9999);               // R7: start clears the flag
    read_word(16'h9999);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule